// File: doc/BRIEF.md
# Cache Control Register Unit

This unit is the software-visible control point for a processor's instruction and data caches. A small 32-bit register bus reaches it. Each access carries a select, a write enable, an address, a size code and write data, and completes in one cycle. The unit holds one control word. That word carries a two-bit operating state for each cache, a freeze-on-interrupt enable for each cache, and a snoop enable. Two fixed configuration words can be read beside it.

When the processor acknowledges an interrupt, it pulses `irq_ack`. Each cache whose freeze enable is set and whose state is enabled then drops to frozen. Any other state is left alone. The unit models register behaviour only; the cache arrays and the flush engines sit elsewhere. The two write-only flush commands are never stored. Instead, each leaves a one-cycle pulse on its own output, for the flush engines to pick up.

Read data is registered. It is valid in the cycle after a read access, and it is zero in every other cycle. The bus has no back-pressure: every access is taken in the cycle it is presented.

Top module: `cache_ctl_regs`

## Requirements
- R1: After reset, the control word is zero, both cache states read 00 (disabled), `snoop_en` is low, both flush pulses are low and `bus_rdata` is zero.
- R2: A word-size write (size code 2) to offset 0x00 stores the write data, except that bits 14, 15, 16, 21 and 22 are stored as zero. A later word read of offset 0x00 returns the stored word.
- R3: `icache_state` shows control bits [1:0] and `dcache_state` shows bits [3:2]. Both use the encoding 00 disabled, 01 frozen, 11 enabled. `snoop_en` shows bit 23.
- R4: On an `irq_ack` cycle with no write, the instruction state changes from 11 to 01 when bit 4 is set. The data state changes from 11 to 01 when bit 5 is set. The two caches are handled independently.
- R5: An `irq_ack` leaves a cache state unchanged if that state is not 11, or if that cache's freeze bit (4 or 5) is clear.
- R6: When a control write and `irq_ack` fall in the same cycle, the written value is stored and the acknowledge has no effect.
- R7: A word read of offset 0x04 returns the parameter `ICFG_WORD` (default 0x10220000). A word read of offset 0x08 returns `DCFG_WORD` (default 0x18220000). Writes to either offset change nothing.
- R8: Any access whose size code is not 2 (0 byte, 1 half, 3 double) is ignored: a write stores nothing and pulses nothing, and a read returns zero.
- R9: A read of any offset other than 0x00, 0x04 or 0x08 returns zero, and a write to such an offset has no effect.
- R10: A word write to offset 0x00 with bit 21 set raises `iflush_o` for exactly the following cycle. With bit 22 set, it raises `dflush_o` in the same way.
- R11: `bus_rdata` holds the read result only in the cycle after a read access, and is zero in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_we | input | 1 | 1 write, 0 read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_size | input | 2 | Size code: 0 byte, 1 half, 2 word, 3 double |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle after a read |
| irq_ack | input | 1 | One-cycle interrupt-acknowledge pulse |
| icache_state | output | 2 | Instruction cache state |
| dcache_state | output | 2 | Data cache state |
| snoop_en | output | 1 | Data cache snoop enable |
| iflush_o | output | 1 | Instruction cache flush pulse |
| dflush_o | output | 1 | Data cache flush pulse |

## Verification
The properties assume that every bus field and `irq_ack` is a clean level, sampled once per clock. They also assume the bus is idle while reset is asserted, since several checks look one cycle back at the access that produced an output. The stimulus drives all inputs on the falling edge and keeps `bus_sel` low throughout reset. A write, a read and an acknowledge are each presented for exactly one cycle, and the bus returns to idle between operations.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

  typedef enum logic [1:0] {
    CS_OFF    = 2'b00,
    CS_FROZEN = 2'b01,
    CS_ON     = 2'b11
  } cache_state_e;

  localparam int unsigned WORD_W      = 32;
  localparam int unsigned NUM_CACHES  = 2;
  localparam int unsigned STATE_W     = 2;
  localparam int unsigned FRZ_BASE    = 4;
  localparam int unsigned IFLUSH_BIT  = 21;
  localparam int unsigned DFLUSH_BIT  = 22;
  localparam int unsigned SNOOP_BIT   = 23;

  localparam logic [1:0] SZ_WORD = 2'd2;

  // bits that never survive a store
  localparam logic [WORD_W-1:0] ZERO_ON_STORE =
      (32'h1 << 14) | (32'h1 << 15) | (32'h1 << 16) |
      (32'h1 << IFLUSH_BIT) | (32'h1 << DFLUSH_BIT);

  typedef struct packed {
    logic wr_ctrl;
    logic rd_ctrl;
    logic rd_icfg;
    logic rd_dcfg;
    logic rd_any;
  } ccr_dec_t;

endpackage

// File: rtl/ccr_decode.sv
module ccr_decode
  import ccr_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned OFF_CTRL = 0,
  parameter int unsigned OFF_ICFG = 4,
  parameter int unsigned OFF_DCFG = 8
) (
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  output ccr_dec_t          dec_o
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_ICFG = ADDR_W'(OFF_ICFG);
  localparam logic [ADDR_W-1:0] A_DCFG = ADDR_W'(OFF_DCFG);

  logic word_ok;
  logic rd_ok;

  always_comb begin
    word_ok       = sel_i && (size_i == SZ_WORD);
    rd_ok         = word_ok && !we_i;
    dec_o.wr_ctrl = word_ok && we_i && (addr_i == A_CTRL);
    dec_o.rd_ctrl = rd_ok && (addr_i == A_CTRL);
    dec_o.rd_icfg = rd_ok && (addr_i == A_ICFG);
    dec_o.rd_dcfg = rd_ok && (addr_i == A_DCFG);
    dec_o.rd_any  = sel_i && !we_i;
  end
endmodule

// File: rtl/ccr_freeze_cell.sv
module ccr_freeze_cell
  import ccr_pkg::*;
(
  input  logic [STATE_W-1:0] state_i,
  input  logic               frz_en_i,
  input  logic               ack_i,
  output logic [STATE_W-1:0] state_o
);
  always_comb begin
    if (ack_i && frz_en_i && (state_i == CS_ON))
      state_o = CS_FROZEN;
    else
      state_o = state_i;
  end
endmodule

// File: rtl/ccr_ctrl_reg.sv
module ccr_ctrl_reg
  import ccr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              ack_i,
  output logic [WORD_W-1:0] ctrl_o,
  output logic              iflush_o,
  output logic              dflush_o
);
  logic [WORD_W-1:0] ctrl_q;
  logic [WORD_W-1:0] frz_word;
  logic [NUM_CACHES-1:0][STATE_W-1:0] st_nxt;

  for (genvar g = 0; g < NUM_CACHES; g++) begin : g_cache
    ccr_freeze_cell u_cell (
      .state_i  (ctrl_q[STATE_W*g +: STATE_W]),
      .frz_en_i (ctrl_q[FRZ_BASE + g]),
      .ack_i    (ack_i),
      .state_o  (st_nxt[g])
    );
  end

  always_comb begin
    frz_word = ctrl_q;
    for (int i = 0; i < NUM_CACHES; i++)
      frz_word[STATE_W*i +: STATE_W] = st_nxt[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      iflush_o <= 1'b0;
      dflush_o <= 1'b0;
    end else begin
      if (wr_i)
        ctrl_q <= wdata_i & ~ZERO_ON_STORE;
      else
        ctrl_q <= frz_word;
      iflush_o <= wr_i && wdata_i[IFLUSH_BIT];
      dflush_o <= wr_i && wdata_i[DFLUSH_BIT];
    end
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/ccr_rdata.sv
module ccr_rdata
  import ccr_pkg::*;
#(
  parameter logic [WORD_W-1:0] ICFG_WORD = 32'h1022_0000,
  parameter logic [WORD_W-1:0] DCFG_WORD = 32'h1822_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ccr_dec_t          dec_i,
  input  logic [WORD_W-1:0] ctrl_i,
  output logic [WORD_W-1:0] rdata_o
);
  logic [WORD_W-1:0] sel_word;

  always_comb begin
    sel_word = '0;
    if (dec_i.rd_ctrl) sel_word = ctrl_i;
    if (dec_i.rd_icfg) sel_word = ICFG_WORD;
    if (dec_i.rd_dcfg) sel_word = DCFG_WORD;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            rdata_o <= '0;
    else if (dec_i.rd_any) rdata_o <= sel_word;
    else                   rdata_o <= '0;
  end
endmodule

// File: rtl/cache_ctl_regs.sv
module cache_ctl_regs
  import ccr_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter logic [31:0] ICFG_WORD = 32'h1022_0000,
  parameter logic [31:0] DCFG_WORD = 32'h1822_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              irq_ack,
  output logic [1:0]        icache_state,
  output logic [1:0]        dcache_state,
  output logic              snoop_en,
  output logic              iflush_o,
  output logic              dflush_o
);
  ccr_dec_t    dec;
  logic [31:0] ctrl_word;

  ccr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .sel_i  (bus_sel),
    .we_i   (bus_we),
    .addr_i (bus_addr),
    .size_i (bus_size),
    .dec_o  (dec)
  );

  ccr_ctrl_reg u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_i     (dec.wr_ctrl),
    .wdata_i  (bus_wdata),
    .ack_i    (irq_ack),
    .ctrl_o   (ctrl_word),
    .iflush_o (iflush_o),
    .dflush_o (dflush_o)
  );

  ccr_rdata #(.ICFG_WORD(ICFG_WORD), .DCFG_WORD(DCFG_WORD)) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .dec_i   (dec),
    .ctrl_i  (ctrl_word),
    .rdata_o (bus_rdata)
  );

  assign icache_state = ctrl_word[1:0];
  assign dcache_state = ctrl_word[3:2];
  assign snoop_en     = ctrl_word[SNOOP_BIT];
endmodule

// File: rtl/ccr_chk.sv
module ccr_chk #(
  parameter int unsigned ADDR_W    = 8,
  parameter logic [31:0] ICFG_WORD = 32'h1022_0000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [1:0]        bus_size,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              irq_ack,
  input logic [1:0]        icache_state,
  input logic [1:0]        dcache_state,
  input logic [31:0]       ctrl_word,
  input logic              iflush_o
);
  logic wr_c, rd_c, rd_i, any_wr, any_rd, bad_rd;
  assign wr_c   = bus_sel && bus_we && bus_addr == '0 && bus_size == 2'd2;
  assign rd_c   = bus_sel && !bus_we && bus_addr == '0 && bus_size == 2'd2;
  assign rd_i   = bus_sel && !bus_we && bus_addr == ADDR_W'(4) && bus_size == 2'd2;
  assign any_wr = bus_sel && bus_we;
  assign any_rd = bus_sel && !bus_we;
  assign bad_rd = bus_sel && !bus_we && bus_size != 2'd2;

  // R2
  masked_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_c) |-> (bus_rdata & 32'h0061_C000) == 32'h0);
  // R4
  ifreeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !any_wr && ctrl_word[4] && icache_state == 2'b11) |=> icache_state == 2'b01);
  // R4
  dfreeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !any_wr && ctrl_word[5] && dcache_state == 2'b11) |=> dcache_state == 2'b01);
  // R5
  ihold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !any_wr && icache_state != 2'b11) |=> $stable(icache_state));
  // R6
  wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_c && irq_ack) |=> dcache_state == $past(bus_wdata[3:2]));
  // R7
  icfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_i) |-> bus_rdata == ICFG_WORD);
  // R8
  bad_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bad_rd) |-> bus_rdata == 32'h0);
  // R10
  iflush_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iflush_o |-> $past(wr_c && bus_wdata[21]));
  // R11
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(any_rd) |-> bus_rdata == 32'h0);
endmodule

bind cache_ctl_regs ccr_chk #(.ADDR_W(ADDR_W), .ICFG_WORD(ICFG_WORD)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_sel      (bus_sel),
  .bus_we       (bus_we),
  .bus_addr     (bus_addr),
  .bus_size     (bus_size),
  .bus_wdata    (bus_wdata),
  .bus_rdata    (bus_rdata),
  .irq_ack      (irq_ack),
  .icache_state (icache_state),
  .dcache_state (dcache_state),
  .ctrl_word    (ctrl_word),
  .iflush_o     (iflush_o)
);

// File: tb/cache_ctl_regs_tb_top.sv
module cache_ctl_regs_tb_top;
  localparam int unsigned AW = 8;
  localparam logic [31:0] MASK = 32'h0061_C000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0, bus_we = 1'b0, irq_ack = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [1:0]    bus_size = 2'd2;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [1:0]    icache_state, dcache_state;
  logic          snoop_en, iflush_o, dflush_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  bit          done = 1'b0;

  always #10 clk = ~clk;

  cache_ctl_regs dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_ack(irq_ack), .icache_state(icache_state),
    .dcache_state(dcache_state), .snoop_en(snoop_en),
    .iflush_o(iflush_o), .dflush_o(dflush_o)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(logic [AW-1:0] a, logic [1:0] sz, logic [31:0] d, logic ack);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_size = sz; bus_wdata = d;
    irq_ack = ack;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; irq_ack = 1'b0; bus_size = 2'd2;
  endtask

  task automatic do_read(logic [AW-1:0] a, logic [1:0] sz, logic [31:0] exp, string req);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a; bus_size = sz;
    exp_q.push_back(exp);
    tag_q.push_back(req);
    @(negedge clk);
    bus_sel = 1'b0; bus_size = 2'd2;
  endtask

  task automatic do_ack();
    @(negedge clk);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  // monitor: pops expected read data after each read access
  initial begin
    forever begin
      @(posedge clk);
      if (rst_n && bus_sel && !bus_we) begin
        #5;
        if (exp_q.size() == 0) begin
          n_chk++; n_bad++;
          $display("FAIL R2 actual=%h expected=<none queued>", bus_rdata);
        end else begin
          check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 istate", {30'b0, icache_state}, 32'h0);
    check("R1 dstate", {30'b0, dcache_state}, 32'h0);
    check("R1 flush", {30'b0, iflush_o, dflush_o}, 32'h0);
    check("R1 rdata", bus_rdata, 32'h0);
    do_read(8'h00, 2'd2, 32'h0, "R1 ctrl");

    // R2 R3 R10 write all ones
    do_write(8'h00, 2'd2, 32'hFFFF_FFFF, 1'b0);
    check("R10 iflush high", {31'b0, iflush_o}, 32'h1);
    check("R10 dflush high", {31'b0, dflush_o}, 32'h1);
    check("R3 istate", {30'b0, icache_state}, 32'h3);
    check("R3 dstate", {30'b0, dcache_state}, 32'h3);
    check("R3 snoop", {31'b0, snoop_en}, 32'h1);
    @(negedge clk);
    check("R10 iflush single", {31'b0, iflush_o}, 32'h0);
    check("R10 dflush single", {31'b0, dflush_o}, 32'h0);
    check("R11 idle rdata", bus_rdata, 32'h0);
    do_read(8'h00, 2'd2, 32'hFFFF_FFFF & ~MASK, "R2 readback");

    // R4 both freeze
    do_ack();
    check("R4 ifreeze", {30'b0, icache_state}, 32'h1);
    check("R4 dfreeze", {30'b0, dcache_state}, 32'h1);
    do_read(8'h00, 2'd2, 32'hFF9E_3FF5, "R4 ctrl");
    // R5 frozen stays
    do_ack();
    check("R5 frozen kept", {28'b0, dcache_state, icache_state}, 32'h5);

    // R4 R5 independent: i on with bit4, d off
    do_write(8'h00, 2'd2, 32'h0000_0013, 1'b0);
    do_ack();
    check("R4 ionly", {30'b0, icache_state}, 32'h1);
    check("R5 doff kept", {30'b0, dcache_state}, 32'h0);
    do_write(8'h00, 2'd2, 32'h0000_002F, 1'b0);
    do_ack();
    check("R5 no ifreeze bit", {30'b0, icache_state}, 32'h3);
    check("R4 donly", {30'b0, dcache_state}, 32'h1);
    do_read(8'h00, 2'd2, 32'h0000_0027, "R4 ctrl2");

    // R6 write and ack together
    do_write(8'h00, 2'd2, 32'h0000_003F, 1'b1);
    check("R6 write wins", {28'b0, dcache_state, icache_state}, 32'hF);

    // R7 config words
    do_read(8'h04, 2'd2, 32'h1022_0000, "R7 icfg");
    do_read(8'h08, 2'd2, 32'h1822_0000, "R7 dcfg");
    do_write(8'h04, 2'd2, 32'h0, 1'b0);
    do_write(8'h08, 2'd2, 32'h0, 1'b0);
    do_read(8'h04, 2'd2, 32'h1022_0000, "R7 icfg after write");
    do_read(8'h00, 2'd2, 32'h0000_003F, "R7 ctrl unchanged");

    // R8 wrong sizes
    do_write(8'h00, 2'd0, 32'h0060_0000, 1'b0);
    check("R8 no flush on byte", {30'b0, iflush_o, dflush_o}, 32'h0);
    do_write(8'h00, 2'd3, 32'h0000_0000, 1'b0);
    do_read(8'h00, 2'd1, 32'h0, "R8 half read");
    do_read(8'h04, 2'd0, 32'h0, "R8 byte read");
    do_read(8'h00, 2'd2, 32'h0000_003F, "R8 ctrl unchanged");

    // R9 unknown offsets
    do_read(8'h0C, 2'd2, 32'h0, "R9 unknown read");
    do_write(8'h0C, 2'd2, 32'h0, 1'b0);
    do_write(8'h01, 2'd2, 32'h0, 1'b0);
    do_read(8'h00, 2'd2, 32'h0000_003F, "R9 ctrl unchanged");

    // R10 only data flush
    do_write(8'h00, 2'd2, 32'h0040_0000, 1'b0);
    check("R10 dflush only", {30'b0, iflush_o, dflush_o}, 32'h1);
    do_read(8'h00, 2'd2, 32'h0, "R10 flush not stored");

    repeat (3) @(negedge clk);
    check("R11 queue drained", exp_q.size(), 32'h0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule